// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the serial control port of a clock generator. It sits on a two-wire bus (a clock line and an open-drain data line) as a target with one fixed 7-bit address. Through it, a host reads and writes a small bank of 8-bit configuration registers. The block runs on a fast system clock and oversamples both bus lines. It recognises start, repeated start and stop conditions. It pulls the data line low through an output-enable signal and never drives it high.

The first byte after the address is a command byte. When its top bit is set, the lower seven bits select one register, and exactly one byte is written or read there. When the top bit is clear, the access is a block transfer that always begins at register 0:

- A block write carries a byte-count byte, followed by data for registers 0, 1, 2 and onward.
- A block read first returns the content of a writable count register, then that many data bytes.

All register contents are presented in parallel to the rest of the chip. A small strap status input is merged into register 0 as read-only bits.

Top module: `cfgslv_top`

## Requirements
- R1: The block acknowledges (pulls the data line low during the ninth clock) an address byte whose upper seven bits are 1101001, so the write address byte is D2h and the read address byte is D3h.
- R2: After an address byte with any other upper seven bits, the block gives no acknowledge and keeps the data line released for all further bytes until the next start condition.
- R3: A command byte with bit 7 = 1 selects the register index in bits 6:0, and the following data byte is written to that index.
- R4: A single-byte read (write phase with a bit-7 = 1 command, repeated start, read address) returns the byte at the selected index MSB first, and the block releases the data line once the host answers NACK.
- R5: A command byte with bit 7 = 0 starts a block write: the next byte is a byte count, and each data byte after it goes to registers 0, 1, 2, … in ascending order. Every byte of the transfer is acknowledged.
- R6: A block read (write phase with command 00h, repeated start, read address) first returns the value of register index 8 (the count register), then data from register 0 upward.
- R7: A block read returns at most the count-register number of data bytes. Any byte the host requests beyond that reads as FFh, because the data line stays released.
- R8: Reset defaults, written as index: default/writable-bit mask in hex, are 0:00/30, 1:F8/F8, 2:BE/BE, 3:C0/FF, 4:00/5A, 5:10/1E, 6:55/FF, 7:18/00, 8:0F/FF, 9:E1/FF, 10:00/FF, 11:B7/FF, 12:B4/FD, 13:A0/E1, 14:A8/1F. Each index appears on the parallel output at bits [8*index+7 : 8*index].
- R9: Bits outside the writable mask keep their default value whatever is written. Index 7 always reads 18h. Register 0 bits 2:0 read back the strap input.
- R10: Indexes 15 to 127 read as 00h, and writes to them change no register.
- R11: A stop after any complete byte ends the transfer, and every byte written before it is kept. Registers not yet reached keep their values.
- R12: A start is a falling data line while the clock line is high, and a stop is a rising data line while the clock line is high. A repeated start in the middle of a byte abandons that byte and restarts address decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When 1, the pad pulls the data line low |
| strapIn | input | 3 | Strap status, read back in register 0 bits 2:0 |
| regOut | output | 120 | All registers in parallel, index i at bits [8i+7:8i] |

## Verification
The hardest case to reach from the ports is the end of a block read after the count limit has run out, because the slave must still be in transmit mode while it returns FFh. The stimulus gets there in two steps. It first lowers the count register to 2 with a single-byte write. It then runs a block read that keeps acknowledging past the second data byte. A second awkward case is a repeated start that cuts off a command byte after three bits. The stimulus causes it by driving partial bit slots by hand before the next start condition, then checks that a complete read still follows correctly.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic shiftIn;    // capture one received bit
    logic idxSet;     // load index from received command bits 6:0
    logic idxZero;    // clear index for block access
    logic idxInc;     // advance index after a write
    logic wrEn;       // write received byte at index
    logic loadCount;  // load transmit byte with the count register
    logic loadData;   // load transmit byte with register data
    logic shiftTx;    // move to next transmit bit
    logic limitOn;    // block read: apply the count limit
  } dpCtl_t;

  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      1: return 8'hF8;  2: return 8'hBE;  3: return 8'hC0;
      5: return 8'h10;  6: return 8'h55;  7: return 8'h18;
      8: return 8'h0F;  9: return 8'hE1;  11: return 8'hB7;
      12: return 8'hB4; 13: return 8'hA0; 14: return 8'hA8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] regMask(input int idx);
    case (idx)
      0: return 8'h30;  1: return 8'hF8;  2: return 8'hBE;
      4: return 8'h5A;  5: return 8'h1E;  7: return 8'h00;
      12: return 8'hFD; 13: return 8'hE1; 14: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgslv_front.sv
module cfgslv_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_STAGES-1];
      sdaPrev <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclLevel = sclSync[SYNC_STAGES-1];
  assign sdaBit   = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign startDet = sclLevel & sclPrev & sdaPrev & ~sdaBit;
  assign stopDet  = sclLevel & sclPrev & ~sdaPrev & sdaBit;

endmodule

// File: rtl/cfgslv_ctrl.sv
module cfgslv_ctrl
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLevel,
  input  logic       sdaBit,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpCtl_t     ctl,
  output logic       sdaOe
);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_TX} state_t;
  typedef enum logic [1:0] {P_ADDR, P_CMD, P_COUNT, P_DATA} phase_t;

  state_t state;
  phase_t phase;
  logic [3:0] bitCnt;
  logic ackOe, txDrive, txNext, blockMode, masterAck;

  wire ackSlotStart = sclFall && (bitCnt == 4'd8);
  wire ackSlotEnd   = sclFall && (bitCnt == 4'd9);

  always_comb begin
    ctl = '0;
    ctl.limitOn = blockMode;
    if (!startDet && !stopDet) begin
      case (state)
        S_RX: begin
          if (sclRise && bitCnt < 4'd8) ctl.shiftIn = 1'b1;
          if (ackSlotStart) begin
            if (phase == P_CMD) begin
              ctl.idxSet  = rxByte[7];
              ctl.idxZero = ~rxByte[7];
            end else if (phase == P_DATA) begin
              ctl.wrEn   = 1'b1;
              ctl.idxInc = 1'b1;
            end
          end
          if (ackSlotEnd && txNext) begin
            ctl.loadCount = blockMode;
            ctl.loadData  = ~blockMode;
          end
        end
        S_TX: begin
          if (sclFall && bitCnt >= 4'd1 && bitCnt <= 4'd7) ctl.shiftTx = 1'b1;
          if (ackSlotEnd && masterAck) ctl.loadData = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      phase     <= P_ADDR;
      bitCnt    <= '0;
      ackOe     <= 1'b0;
      txDrive   <= 1'b0;
      txNext    <= 1'b0;
      blockMode <= 1'b0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      state   <= S_RX;
      phase   <= P_ADDR;
      bitCnt  <= '0;
      ackOe   <= 1'b0;
      txDrive <= 1'b0;
      txNext  <= 1'b0;
    end else if (stopDet) begin
      state   <= S_IDLE;
      ackOe   <= 1'b0;
      txDrive <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (sclRise) begin
            if (bitCnt < 4'd8)       bitCnt <= bitCnt + 4'd1;
            else if (bitCnt == 4'd8) bitCnt <= 4'd9;
          end
          if (ackSlotStart) begin
            case (phase)
              P_ADDR: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  ackOe  <= 1'b1;
                  txNext <= rxByte[0];
                  phase  <= P_CMD;
                end else begin
                  state <= S_IDLE;
                end
              end
              P_CMD: begin
                ackOe     <= 1'b1;
                blockMode <= ~rxByte[7];
                phase     <= rxByte[7] ? P_DATA : P_COUNT;
              end
              P_COUNT: begin
                ackOe <= 1'b1;
                phase <= P_DATA;
              end
              default: ackOe <= 1'b1;
            endcase
          end
          if (ackSlotEnd) begin
            ackOe  <= 1'b0;
            bitCnt <= '0;
            if (txNext) begin
              state   <= S_TX;
              txDrive <= 1'b1;
            end
          end
        end
        S_TX: begin
          if (sclRise) begin
            if (bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
            else if (bitCnt == 4'd8) begin
              bitCnt    <= 4'd9;
              masterAck <= ~sdaBit;
            end
          end
          if (ackSlotStart) txDrive <= 1'b0;
          if (ackSlotEnd) begin
            if (masterAck) begin
              bitCnt  <= '0;
              txDrive <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = ackOe | (txDrive & ~txMsb);

  // R2: an idle slave never holds the data line
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe);

  // R1: the slave only starts pulling the line while the bus clock is low
  assert_oe_rise_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLevel);

  // R12: a start condition restarts address reception
  assert_start_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_RX && phase == P_ADDR && bitCnt == 4'd0));

  // R2: a mismatching address leaves the slave idle
  assert_addr_mismatch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX && phase == P_ADDR && ackSlotStart && !startDet && !stopDet
     && rxByte[7:1] != DEV_ADDR) |=> (state == S_IDLE));

endmodule

// File: rtl/cfgslv_datapath.sv
module cfgslv_datapath
  import cfgslv_pkg::*;
#(
  parameter int NUM_REGS  = 15,
  parameter int COUNT_IDX = 8,
  parameter int STRAP_W   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtl_t                ctl,
  input  logic                  sdaBit,
  input  logic [STRAP_W-1:0]    strapIn,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] regOut
);

  localparam int IDX_W = 7;

  logic [7:0] rxShift, txShift, remain, rdData;
  logic [IDX_W-1:0] idx;
  logic [7:0] regVal [NUM_REGS];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gReg
      localparam logic [7:0] DEF  = regDefault(g);
      localparam logic [7:0] MASK = regMask(g);
      logic [7:0] stored;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stored <= DEF;
        else if (ctl.wrEn && idx == IDX_W'(g))
          stored <= (rxShift & MASK) | (stored & ~MASK);
      end
      assign regVal[g] = (stored & MASK) | (DEF & ~MASK);
      assign regOut[g*8 +: 8] = regVal[g];
    end
  endgenerate

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) rdData = regVal[i];
    end
    if (idx == '0) rdData = regVal[0] | {{(8-STRAP_W){1'b0}}, strapIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= 8'hFF;
      remain  <= '0;
      idx     <= '0;
    end else begin
      if (ctl.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (ctl.idxSet)       idx <= rxShift[IDX_W-1:0];
      else if (ctl.idxZero) idx <= '0;
      else if (ctl.idxInc || ctl.loadData) idx <= idx + 1'b1;
      if (ctl.loadCount) begin
        txShift <= regVal[COUNT_IDX];
        remain  <= regVal[COUNT_IDX];
      end else if (ctl.loadData) begin
        if (ctl.limitOn && remain == '0) txShift <= 8'hFF;
        else txShift <= rdData;
        if (ctl.limitOn && remain != '0) remain <= remain - 8'd1;
      end else if (ctl.shiftTx) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];

  // R6: the first byte of a block read is the count register
  assert_count_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCount |=> (txShift == $past(regVal[COUNT_IDX])));

  // R7: once the limit is used up, the slave sends all ones
  assert_limit_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadData && ctl.limitOn && remain == '0) |=> (txShift == 8'hFF));

  // R10: writes beyond the bank leave every register unchanged
  assert_unimpl_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && idx >= IDX_W'(NUM_REGS)) |=> (regOut == $past(regOut)));

  // R3: a write to the count register lands there whole
  assert_count_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && idx == IDX_W'(COUNT_IDX)) |=> (regVal[COUNT_IDX] == $past(rxShift)));

endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 15,
  parameter int         COUNT_IDX   = 8,
  parameter int         STRAP_W     = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [STRAP_W-1:0]    strapIn,
  output logic [NUM_REGS*8-1:0] regOut
);

  logic sclLevel, sdaBit, sclRise, sclFall, startDet, stopDet, txMsb;
  logic [7:0] rxByte;
  dpCtl_t ctl;

  cfgslv_front #(.SYNC_STAGES(SYNC_STAGES)) uFront (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaBit(sdaBit), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  cfgslv_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaBit(sdaBit),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .rxByte(rxByte), .txMsb(txMsb),
    .ctl(ctl), .sdaOe(sdaOe)
  );

  cfgslv_datapath #(.NUM_REGS(NUM_REGS), .COUNT_IDX(COUNT_IDX), .STRAP_W(STRAP_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaBit(sdaBit), .strapIn(strapIn),
    .rxByte(rxByte), .txMsb(txMsb), .regOut(regOut)
  );

endmodule

// File: tb/cfgslv_top_test.sv
module cfgslv_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NREG = 15;
  localparam int WATCHDOG = 150000;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sdaOe;
  logic [NREG*8-1:0] regOut;
  wire sdaLine = msda & ~sdaOe;

  int testCnt = 0;
  int failCnt = 0;
  logic [7:0] shadow [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgslv_top uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .strapIn(STRAP), .regOut(regOut)
  );

  function automatic logic [7:0] defOf(input int i);
    logic [7:0] t [NREG] = '{8'h00, 8'hF8, 8'hBE, 8'hC0, 8'h00, 8'h10, 8'h55, 8'h18,
                             8'h0F, 8'hE1, 8'h00, 8'hB7, 8'hB4, 8'hA0, 8'hA8};
    return t[i];
  endfunction

  function automatic logic [7:0] maskOf(input int i);
    logic [7:0] t [NREG] = '{8'h30, 8'hF8, 8'hBE, 8'hFF, 8'h5A, 8'h1E, 8'hFF, 8'h00,
                             8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFD, 8'hE1, 8'h1F};
    return t[i];
  endfunction

  function automatic logic [7:0] expRead(input int i);
    if (i == 0) return shadow[0] | {5'b0, STRAP};
    if (i < NREG) return shadow[i];
    return 8'h00;
  endfunction

  task automatic modelWrite(input int i, input logic [7:0] d);
    if (i < NREG) shadow[i] = (d & maskOf(i)) | (shadow[i] & ~maskOf(i));
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    msda = 1'b1; waitQ();
    scl = 1'b1;  waitQ();
    msda = 1'b0; waitQ();
    scl = 1'b0;  waitQ();
  endtask

  task automatic busStop();
    msda = 1'b0; waitQ();
    scl = 1'b1;  waitQ();
    msda = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    msda = b;   waitQ();
    scl = 1'b1; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic wrByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    msda = 1'b1; waitQ();
    scl = 1'b1;  waitQ();
    ack = (sdaLine == 1'b0);
    scl = 1'b0;  waitQ();
  endtask

  task automatic rdByte(input bit giveAck, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      scl = 1'b1; waitQ();
      b[i] = sdaLine;
      scl = 1'b0;
    end
    waitQ();
    msda = giveAck ? 1'b0 : 1'b1; waitQ();
    scl = 1'b1; waitQ();
    scl = 1'b0; waitQ();
    msda = 1'b1;
  endtask

  task automatic singleWrite(input logic [6:0] idx, input logic [7:0] d, output bit allAck);
    bit a1, a2, a3;
    busStart();
    wrByte(8'hD2, a1); wrByte({1'b1, idx}, a2); wrByte(d, a3);
    busStop();
    allAck = a1 & a2 & a3;
    modelWrite(int'(idx), d);
  endtask

  task automatic singleRead(input logic [6:0] idx, output logic [7:0] d, output bit allAck);
    bit a1, a2, a3;
    busStart();
    wrByte(8'hD2, a1); wrByte({1'b1, idx}, a2);
    busStart();
    wrByte(8'hD3, a3);
    rdByte(1'b0, d);
    busStop();
    allAck = a1 & a2 & a3;
  endtask

  task automatic checkRegOut(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(regOut[i*8 +: 8] == shadow[i], tag, regOut[i*8 +: 8], shadow[i]);
  endtask

  task automatic testReset();
    chk(sdaOe == 1'b0, "R8 sdaOe after reset", sdaOe, 0);
    checkRegOut("R8 reset default");
  endtask

  task automatic testReadOnly();
    logic [7:0] d; bit a;
    singleRead(7'd7, d, a);
    chk(a, "R1 address/cmd ack", a, 1);
    chk(d == 8'h18, "R9 index 7 id", d, 8'h18);
    singleWrite(7'd7, 8'h00, a);
    singleRead(7'd7, d, a);
    chk(d == 8'h18, "R9 index 7 after write", d, 8'h18);
    singleRead(7'd0, d, a);
    chk(d == expRead(0), "R9 strap bits", d, expRead(0));
    singleWrite(7'd0, 8'hFF, a);
    singleRead(7'd0, d, a);
    chk(d == expRead(0), "R9 masked write idx0", d, expRead(0));
  endtask

  task automatic testSingle();
    logic [7:0] d; bit a;
    singleWrite(7'd6, 8'h3C, a);
    chk(a, "R3 write acks", a, 1);
    chk(regOut[6*8 +: 8] == 8'h3C, "R3 idx6 stored", regOut[6*8 +: 8], 8'h3C);
    singleRead(7'd6, d, a);
    chk(d == 8'h3C, "R4 read idx6", d, 8'h3C);
    chk(sdaOe == 1'b0, "R4 released after nack", sdaOe, 0);
    singleWrite(7'd12, 8'hFF, a);
    singleRead(7'd12, d, a);
    chk(d == expRead(12), "R4 read idx12 masked", d, expRead(12));
  endtask

  task automatic testMismatch();
    bit a; logic [7:0] d; bit sawOe = 1'b0;
    busStart();
    wrByte(8'hA0, a);
    chk(!a, "R2 wrong address no ack", a, 0);
    wrByte(8'h86, a); sawOe |= a;
    wrByte(8'h00, a); sawOe |= a;
    chk(!sawOe, "R2 ignored bytes no ack", sawOe, 0);
    busStop();
    busStart();
    wrByte(8'hD3 ^ 8'h02, a);
    chk(!a, "R2 read to other address", a, 0);
    busStop();
    singleRead(7'd6, d, a);
    chk(d == expRead(6), "R2 idx6 unchanged", d, expRead(6));
    checkRegOut("R2 bank unchanged");
  endtask

  task automatic testUnimpl();
    logic [7:0] d; bit a;
    singleWrite(7'd20, 8'h77, a);
    singleRead(7'd20, d, a);
    chk(d == 8'h00, "R10 unimplemented reads zero", d, 0);
    singleRead(7'd127, d, a);
    chk(d == 8'h00, "R10 index 127 reads zero", d, 0);
    checkRegOut("R10 bank unchanged");
  endtask

  task automatic testBlockWrite();
    bit a, all; logic [7:0] vals [3] = '{8'hA1, 8'h5C, 8'h3F};
    busStart();
    wrByte(8'hD2, a); all = a;
    wrByte(8'h00, a); all &= a;
    wrByte(8'h03, a); all &= a;
    for (int i = 0; i < 3; i++) begin
      wrByte(vals[i], a); all &= a;
      modelWrite(i, vals[i]);
    end
    busStop();
    chk(all, "R5 every byte acked", all, 1);
    checkRegOut("R5 block write contents");
  endtask

  task automatic testBlockRead();
    bit a; logic [7:0] d;
    busStart();
    wrByte(8'hD2, a); wrByte(8'h00, a);
    busStart(); wrByte(8'hD3, a);
    rdByte(1'b1, d);
    chk(d == expRead(8), "R6 count byte", d, expRead(8));
    for (int i = 0; i < 3; i++) begin
      rdByte(i != 2, d);
      chk(d == expRead(i), "R6 block data", d, expRead(i));
    end
    busStop();
    singleWrite(7'd8, 8'h02, a);
    busStart();
    wrByte(8'hD2, a); wrByte(8'h00, a);
    busStart(); wrByte(8'hD3, a);
    rdByte(1'b1, d);
    chk(d == 8'h02, "R7 lowered count", d, 2);
    rdByte(1'b1, d);
    chk(d == expRead(0), "R7 data0", d, expRead(0));
    rdByte(1'b1, d);
    chk(d == expRead(1), "R7 data1", d, expRead(1));
    rdByte(1'b1, d);
    chk(d == 8'hFF, "R7 beyond limit", d, 8'hFF);
    rdByte(1'b0, d);
    chk(d == 8'hFF, "R7 beyond limit second", d, 8'hFF);
    busStop();
    chk(sdaOe == 1'b0, "R7 released at end", sdaOe, 0);
  endtask

  task automatic testStopEarly();
    bit a;
    busStart();
    wrByte(8'hD2, a); wrByte(8'h00, a); wrByte(8'h05, a);
    wrByte(8'h10, a); modelWrite(0, 8'h10);
    wrByte(8'h08, a); modelWrite(1, 8'h08);
    busStop();
    checkRegOut("R11 partial block kept");
    busStart();
    wrByte(8'hD2, a); wrByte(8'h83, a);
    busStop();
    checkRegOut("R11 stop after command");
  endtask

  task automatic testRestart();
    bit a; logic [7:0] d;
    busStart();
    wrByte(8'hD2, a);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStart();
    wrByte(8'hD2, a);
    chk(a, "R12 address after restart", a, 1);
    wrByte(8'h89, a);
    busStart();
    wrByte(8'hD3, a);
    rdByte(1'b0, d);
    busStop();
    chk(d == expRead(9), "R12 read after cut byte", d, expRead(9));
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) shadow[i] = defOf(i);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testReadOnly();
    testSingle();
    testMismatch();
    testUnimpl();
    testBlockWrite();
    testBlockRead();
    testStopEarly();
    testRestart();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule